// File: doc/BRIEF.md
# Edge-to-Pulse Isolation Encoder

This block is the transmit half of one channel of a pulse-coded isolation link. A link of this kind cannot hold a static level; it only carries short events. The encoder therefore turns a single logic input into two one-clock pulse outputs. A set pulse goes out when the input has risen, and a clear pulse goes out when it has fallen. On the far side, a bistable element is flipped by these pulses and rebuilds the level.

The raw input first passes through a two-flop synchronizer and then a glitch filter. The filter accepts a new level only after the level has been stable for `FILT_CYCLES` consecutive clocks. Edge pulses are taken from the filtered level. A refresh timer watches for quiet periods: once `REFRESH_CYCLES` clocks pass with no pulse, the encoder sends the pulse that matches the current level. It then keeps doing so at that interval for as long as the input stays still. This lets a receiver that missed an edge, or has just powered up, settle to the correct DC level. Coming out of reset, the filtered level is low and the timer starts from zero, so the link is driven to a known state within one interval.

Top module: `edge_pulse_enc`

## Requirements
- R1: After `din` rises and stays high, `set_o` pulses exactly once. The pulse is visible in the clock period that follows the (FILT_CYCLES+3)-th rising clock edge after the change: 2 synchronizer edges, FILT_CYCLES filter samples, 1 output register.
- R2: After `din` falls and stays low, `clr_o` pulses exactly once, with the same latency as R1.
- R3: Every pulse on `set_o` or `clr_o` is exactly one clock wide. The two outputs are never high in the same cycle.
- R4: The input must differ from the accepted level on FILT_CYCLES consecutive synchronized samples before it is accepted. A spike that lasts fewer clocks produces no pulse. A spike that lasts exactly FILT_CYCLES clocks is accepted and produces a pulse.
- R5: When REFRESH_CYCLES clocks pass after the last pulse with no new pulse, a refresh pulse is sent: `set_o` if the filtered level is high, `clr_o` if it is low. The refresh repeats every REFRESH_CYCLES clocks while the input stays idle.
- R6: Every emitted pulse, whether edge or refresh, restarts the refresh interval. The next refresh comes REFRESH_CYCLES clocks after the latest pulse.
- R7: While `rst` is high, both outputs are low and the filtered level is low. After `rst` is released with `din` low, the first pulse is a `clr_o` refresh exactly REFRESH_CYCLES clocks later. With `din` high, a `set_o` edge pulse follows with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Asynchronous logic input to be carried across the link |
| set_o | output | 1 | One-clock pulse: remote level must become high |
| clr_o | output | 1 | One-clock pulse: remote level must become low |

## Verification
A wrong filtered level or filter count shows up at the ports as a missing pulse, an extra pulse, or a pulse of the wrong polarity. It appears within FILT_CYCLES+3 clocks of the input change, so the bench measures the exact cycle of the first pulse in each window, not just the number of pulses. A wrong refresh timer shows up only after a full idle interval, as a refresh one cycle early or late, or as one missing after an edge has restarted the timer. The bench therefore places idle stretches so that a refresh must land on a known cycle. It also includes a case where a stale timer would fire about ten cycles too early.

// File: rtl/epe_pkg.sv
package epe_pkg;

    // Depth of the input synchronizer; the latency formula in the brief assumes 2.
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        PULSE_IDLE = 2'b00,
        PULSE_SET  = 2'b01,
        PULSE_CLR  = 2'b10
    } pulse_e;

    // Output of the glitch filter: the accepted level and a one-cycle flag on change.
    typedef struct packed {
        logic level;
        logic moved;
    } filt_out_t;

    // Pulse that restores a given level at the receiver.
    function automatic pulse_e pulse_for(input logic lvl);
        return lvl ? PULSE_SET : PULSE_CLR;
    endfunction

endpackage

// File: rtl/epe_sync.sv
module epe_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], d};
        end
    end

    assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/epe_filter.sv
module epe_filter
    import epe_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output filt_out_t fout
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          moved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
            moved_q <= 1'b0;
        end else begin
            moved_q <= 1'b0;
            if (raw == level_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                level_q <= raw;
                run_q   <= '0;
                moved_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign fout.level = level_q;
    assign fout.moved = moved_q;
endmodule

// File: rtl/epe_pulse_gen.sv
module epe_pulse_gen
    import epe_pkg::*;
#(
    parameter int REFRESH_CYCLES = 100
) (
    input  logic      clk,
    input  logic      rst,
    input  filt_out_t fin,
    output logic      set_o,
    output logic      clr_o
);
    localparam int TW = $clog2(REFRESH_CYCLES);
    localparam logic [TW-1:0] DUE = TW'(REFRESH_CYCLES - 1);

    logic [TW-1:0] idle_q;
    pulse_e        next_pulse;

    always_comb begin
        if (fin.moved) begin
            next_pulse = pulse_for(fin.level);
        end else if (idle_q == DUE) begin
            next_pulse = pulse_for(fin.level);
        end else begin
            next_pulse = PULSE_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
            set_o  <= 1'b0;
            clr_o  <= 1'b0;
        end else begin
            if (next_pulse != PULSE_IDLE) begin
                idle_q <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
            set_o <= (next_pulse == PULSE_SET);
            clr_o <= (next_pulse == PULSE_CLR);
        end
    end
endmodule

// File: rtl/edge_pulse_enc.sv
module edge_pulse_enc
    import epe_pkg::*;
#(
    parameter int FILT_CYCLES    = 4,
    parameter int REFRESH_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic set_o,
    output logic clr_o
);
    logic      sync_q;
    filt_out_t filt;
    logic      flt_level;

    epe_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (sync_q)
    );

    epe_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
        .clk  (clk),
        .rst  (rst),
        .raw  (sync_q),
        .fout (filt)
    );

    epe_pulse_gen #(.REFRESH_CYCLES(REFRESH_CYCLES)) gen_i (
        .clk   (clk),
        .rst   (rst),
        .fin   (filt),
        .set_o (set_o),
        .clr_o (clr_o)
    );

    assign flt_level = filt.level;
endmodule

// File: rtl/edge_pulse_enc_checker.sv
module edge_pulse_enc_checker #(
    parameter int REFRESH_CYCLES = 100
) (
    input logic clk,
    input logic rst,
    input logic set_o,
    input logic clr_o,
    input logic level,
    input logic sync_q
);
    localparam int GW = $clog2(REFRESH_CYCLES + 2);
    localparam logic [GW-1:0] GAP_DUE = GW'(REFRESH_CYCLES);
    localparam logic [GW-1:0] GAP_TOP = GW'(REFRESH_CYCLES + 1);

    // Clocks since the last pulse, counted so that a due refresh sees GAP_DUE.
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (set_o || clr_o) begin
            gap_q <= GW'(1);
        end else if (gap_q != GAP_TOP) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(set_o && clr_o));

    assert_set_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        set_o |=> !set_o);

    assert_clr_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o);

    assert_set_polarity_R1: assert property (@(posedge clk) disable iff (rst)
        set_o |-> $past(level));

    assert_clr_polarity_R2: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> !$past(level));

    assert_filter_source_R4: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(sync_q) == level));

    assert_refresh_due_R5: assert property (@(posedge clk) disable iff (rst)
        (gap_q == GAP_DUE) |-> (set_o || clr_o));
endmodule

bind edge_pulse_enc edge_pulse_enc_checker #(.REFRESH_CYCLES(REFRESH_CYCLES)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .set_o  (set_o),
    .clr_o  (clr_o),
    .level  (flt_level),
    .sync_q (sync_q)
);

// File: tb/edge_pulse_enc_tb_top.sv
module edge_pulse_enc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 3;
    localparam int REFRESH    = 20;
    localparam int LAT        = FILT + 3;

    typedef struct packed {
        logic       din;
        logic [7:0] hold;
        logic [3:0] n_set;
        logic [3:0] n_clr;
        logic [7:0] first;
    } vec_t;

    localparam int NV = 11;
    // Each step: drive din, run 'hold' clocks, expect pulse counts and first pulse cycle (0 = none).
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd10, 4'd1, 4'd0, 8'd6},   // R1 rising edge
        '{1'b0, 8'd10, 4'd0, 4'd1, 8'd6},   // R2 falling edge
        '{1'b1, 8'd2,  4'd0, 4'd0, 8'd0},   // R4 two-cycle spike
        '{1'b0, 8'd10, 4'd0, 4'd0, 8'd0},   // R4 spike rejected
        '{1'b1, 8'd10, 4'd1, 4'd1, 8'd4},   // R5 low refresh, then R1 edge
        '{1'b0, 8'd1,  4'd0, 4'd0, 8'd0},   // R4 one-cycle dip
        '{1'b1, 8'd9,  4'd0, 4'd0, 8'd0},   // R4 dip rejected
        '{1'b1, 8'd6,  4'd1, 4'd0, 8'd6},   // R5 high refresh
        '{1'b1, 8'd20, 4'd1, 4'd0, 8'd20},  // R5 refresh repeats
        '{1'b0, 8'd3,  4'd0, 4'd0, 8'd0},   // R4 dip of exactly FILT clocks
        '{1'b1, 8'd12, 4'd1, 4'd1, 8'd3}    // R4 dip accepted, R1 edge back
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic set_o;
    logic clr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_pulse_enc #(.FILT_CYCLES(FILT), .REFRESH_CYCLES(REFRESH)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .set_o (set_o),
        .clr_o (clr_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n, output int ns, output int nc, output int first, output int both);
        ns = 0; nc = 0; first = 0; both = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (set_o) ns++;
            if (clr_o) nc++;
            if (set_o && clr_o) both++;
            if (first == 0 && (set_o || clr_o)) first = i;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ns, nc, first, both, both_total;
        both_total = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!set_o && !clr_o, "R7 outputs low in reset", int'(set_o) + int'(clr_o), 0);
        rst = 1'b0;

        // R7 / R5: first refresh after reset with din low is a clear, REFRESH clocks later
        run(REFRESH, ns, nc, first, both);
        both_total += both;
        check(ns == 0, "R7 no set after reset", ns, 0);
        check(nc == 1, "R7 one clear after reset", nc, 1);
        check(first == REFRESH, "R7 clear cycle after reset", first, REFRESH);

        for (int i = 0; i < NV; i++) begin
            din = VECS[i].din;
            run(int'(VECS[i].hold), ns, nc, first, both);
            both_total += both;
            check(ns == int'(VECS[i].n_set), $sformatf("R1/R5 set count step %0d", i), ns, int'(VECS[i].n_set));
            check(nc == int'(VECS[i].n_clr), $sformatf("R2/R5 clear count step %0d", i), nc, int'(VECS[i].n_clr));
            check(first == int'(VECS[i].first), $sformatf("R4/R6 first pulse cycle step %0d", i), first, int'(VECS[i].first));
        end

        // R7: reset mid-activity with din high
        din = 1'b1;
        rst = 1'b1;
        run(2, ns, nc, first, both);
        check(ns + nc == 0, "R7 no pulse while reset", ns + nc, 0);
        rst = 1'b0;
        run(10, ns, nc, first, both);
        both_total += both;
        check(ns == 1 && nc == 0, "R7 set after reset with din high", ns * 10 + nc, 10);
        check(first == LAT, "R1 latency after reset", first, LAT);

        // R6: clear edge restarts the interval; stale timer would fire early
        din = 1'b0;
        run(10, ns, nc, first, both);
        both_total += both;
        check(nc == 1 && ns == 0, "R2 clear edge", nc * 10 + ns, 10);
        check(first == LAT, "R2 clear latency", first, LAT);
        run(19, ns, nc, first, both);
        both_total += both;
        check(nc == 1 && ns == 0, "R6 single refresh after edge", nc * 10 + ns, 10);
        check(first == REFRESH - 4, "R6 refresh cycle after edge", first, REFRESH - 4);

        check(both_total == 0, "R3 set and clear never together", both_total, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule